// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Ready Handshake

This block receives 8-bit frames over a two-wire synchronous link (serial clock plus data) and hands each completed byte to a CPU through a one-deep receive holding register. It works in one of two roles, chosen by a static mode input.

As the clock master, it produces the serial clock itself from the system clock through a programmable divider. It starts a frame only while the peer's active-low ready line is low. As the clock slave, it follows an external serial clock. It pulls its own active-low ready output high while the holding register is occupied, which tells the far-end master to stop clocking.

In both roles, data is sampled on rising serial-clock edges. The bit that arrives first becomes bit 0 of the byte. When a byte completes, the block raises a full flag and a one-cycle interrupt pulse. If a byte completes while the previous byte is still unread, the new byte is discarded and a sticky overrun error is raised.

Top module: `clksync_rx`

## Requirements
- R1: After reset the following outputs are low: `buf_full`, `rx_irq` and `ovr_err`. `sclk_out` is high. `rdy_n_out` is low in slave mode (`mode_master`=0).
- R2: Bits are assembled least significant first: the first bit sampled in a frame appears at `rx_data[0]` and the eighth at `rx_data[7]`.
- R3: In master mode, while idle, `sclk_out` stays high and no frame starts as long as `peer_rdy_n` is high.
- R4: In master mode, `sclk_out` toggles every `clk_div`+1 system cycles, and each frame contains exactly 8 low pulses, the first being a falling edge.
- R5: Data is taken on rising serial-clock edges (`sclk_in` in slave mode, `sclk_out` in master mode), so a sender that changes `sdata_in` on falling edges is received correctly.
- R6: When the eighth bit is taken, and the register is empty (or being read in the same cycle), the byte is loaded into `rx_data`, `buf_full` becomes 1 and `rx_irq` pulses high for exactly one system cycle.
- R7: A `rd_stb` pulse clears `buf_full` unless a new byte is loaded in the same cycle.
- R8: In slave mode `rdy_n_out` equals `buf_full` (high = busy); in master mode it is held high.
- R9: A byte that completes while `buf_full`=1 and no read occurs sets `ovr_err`, leaves `rx_data` unchanged and produces no `rx_irq`.
- R10: `ovr_err` stays set, including across reads, until an `ovr_clr` pulse.
- R11: A byte that completes in the same cycle as a `rd_stb` pulse is accepted without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_master | input | 1 | 1 = generate serial clock, 0 = follow external clock |
| clk_div | input | DIV_W | Master half period minus one, in system cycles (at least 2) |
| peer_rdy_n | input | 1 | Peer ready, active low (master mode) |
| sclk_in | input | 1 | External serial clock (slave mode) |
| sdata_in | input | 1 | Serial data |
| sclk_out | output | 1 | Generated serial clock, idles high |
| rdy_n_out | output | 1 | Own ready, active low (slave mode) |
| rd_stb | input | 1 | CPU read of the receive register |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_data | output | DATA_W | Receive holding register |
| buf_full | output | 1 | Holding register contains an unread byte |
| rx_irq | output | 1 | One-cycle pulse per accepted byte |
| ovr_err | output | 1 | Sticky overrun error |

## Verification
The hardest cases come from the timing of a slave-mode frame relative to the holding register. A well-behaved master stops when `rdy_n_out` goes high, so an overrun can only occur if the bench ignores the busy signal and keeps clocking. The bench does exactly that on purpose. It also schedules a read pulse so that it lands in the exact system cycle in which the eighth rising edge clears the synchronizer. This lets it test the simultaneous read-and-load case. Master-mode stalls are exercised by holding the peer ready line high for a long idle stretch. The bench also releases that line at the eighth falling edge, which shows that the master stops after one frame.

// File: rtl/clksync_rx.sv
module clksync_rx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_master,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              peer_rdy_n,
  input  logic              sclk_in,
  input  logic              sdata_in,
  output logic              sclk_out,
  output logic              rdy_n_out,
  input  logic              rd_stb,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              buf_full,
  output logic              rx_irq,
  output logic              ovr_err
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [2:0]        sck_s;
  logic [1:0]        din_s;
  logic [1:0]        rdy_s;
  logic              mode_q;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              mst_act;
  logic [DIV_W-1:0]  div_cnt;
  logic              sclk_r;

  wire s_rise   = sck_s[1] & ~sck_s[2];
  wire div_hit  = (div_cnt == clk_div);
  wire m_rise   = mst_act & div_hit & ~sclk_r;
  wire shift_ev = mode_master ? m_rise : s_rise;
  wire last_bit = shift_ev & (bitcnt == LAST);
  wire accept   = last_bit & (~buf_full | rd_stb);
  wire overrun  = last_bit & buf_full & ~rd_stb;
  wire [DATA_W-1:0] next_sh = {din_s[1], shreg[DATA_W-1:1]};

  assign sclk_out  = sclk_r;
  assign rdy_n_out = mode_master | buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= 3'b111;
      din_s  <= 2'b00;
      rdy_s  <= 2'b11;
      mode_q <= 1'b0;
    end else begin
      sck_s  <= {sck_s[1:0], sclk_in};
      din_s  <= {din_s[0], sdata_in};
      rdy_s  <= {rdy_s[0], peer_rdy_n};
      mode_q <= mode_master;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_act <= 1'b0;
      div_cnt <= '0;
      sclk_r  <= 1'b1;
    end else if (!mode_master || !mst_act) begin
      sclk_r  <= 1'b1;
      div_cnt <= '0;
      mst_act <= mode_master & mode_q & ~rdy_s[1];
    end else if (div_hit) begin
      div_cnt <= '0;
      sclk_r  <= ~sclk_r;
      if (m_rise && bitcnt == LAST) mst_act <= 1'b0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (mode_q != mode_master) begin
      bitcnt <= '0;
    end else if (shift_ev) begin
      shreg  <= next_sh;
      bitcnt <= last_bit ? '0 : bitcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      buf_full <= 1'b0;
      rx_irq   <= 1'b0;
      ovr_err  <= 1'b0;
    end else begin
      rx_irq <= accept;
      if (accept) begin
        rx_data  <= next_sh;
        buf_full <= 1'b1;
      end else if (rd_stb) begin
        buf_full <= 1'b0;
      end
      if (overrun)      ovr_err <= 1'b1;
      else if (ovr_clr) ovr_err <= 1'b0;
    end
  end

endmodule

// File: rtl/clksync_rx_chk.sv
module clksync_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_master,
  input logic              mst_act,
  input logic              sclk_out,
  input logic              rd_stb,
  input logic              ovr_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              buf_full,
  input logic              rx_irq,
  input logic              ovr_err
);

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  assert_irq_with_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> buf_full);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (!buf_full || rx_irq));

  assert_data_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !rd_stb) |=> $stable(rx_data));

  assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && !ovr_clr) |=> ovr_err);

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_master && $past(mode_master) && !mst_act && !$past(mst_act)) |-> sclk_out);

endmodule

bind clksync_rx clksync_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .mst_act(mst_act),
  .sclk_out(sclk_out), .rd_stb(rd_stb), .ovr_clr(ovr_clr), .rx_data(rx_data),
  .buf_full(buf_full), .rx_irq(rx_irq), .ovr_err(ovr_err)
);

// File: tb/tb_clksync_rx.sv
module tb_clksync_rx;
  localparam int HALF = 6;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       mode_master = 0;
  logic [7:0] clk_div = 8'd3;
  logic       peer_rdy_n = 1;
  logic       sclk_in = 1;
  logic       sdata_in = 0;
  logic       rd_stb = 0;
  logic       ovr_clr = 0;
  logic       sclk_out, rdy_n_out, buf_full, rx_irq, ovr_err;
  logic [7:0] rx_data;

  int checks = 0, fails = 0;
  int cyc = 0, falls = 0, rise_cyc = 0, fall_cyc = 0, irqs = 0;
  logic prev_sclk = 1;
  bit summary_done = 0;
  logic [7:0] expq[$];

  always #5 clk = ~clk;

  clksync_rx dut (
    .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .clk_div(clk_div),
    .peer_rdy_n(peer_rdy_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .sclk_out(sclk_out), .rdy_n_out(rdy_n_out), .rd_stb(rd_stb), .ovr_clr(ovr_clr),
    .rx_data(rx_data), .buf_full(buf_full), .rx_irq(rx_irq), .ovr_err(ovr_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (prev_sclk && !sclk_out) begin falls++; fall_cyc = cyc; end
    if (!prev_sclk && sclk_out) rise_cyc = cyc;
    prev_sclk = sclk_out;
    if (rx_irq && rst_n) begin
      irqs++;
      if (expq.size() == 0) chk("R9 unexpected irq", 1, 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk("R2/R5/R6 byte", rx_data, e);
      end
    end
  end

  task automatic slave_send(input logic [7:0] b, input bit push, input bit rd_at_end);
    if (push) expq.push_back(b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sclk_in = 0; sdata_in = b[i];
      repeat (HALF - 1) @(negedge clk);
      sclk_in = 1;
      if (rd_at_end && i == 7) begin
        repeat (2) @(negedge clk); rd_stb = 1;
        @(negedge clk); rd_stb = 0;
        repeat (HALF - 3) @(negedge clk);
      end else repeat (HALF - 1) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic cpu_read();
    @(negedge clk); rd_stb = 1;
    @(negedge clk); rd_stb = 0;
  endtask

  task automatic master_recv(input logic [7:0] b);
    expq.push_back(b);
    peer_rdy_n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge sclk_out);
      sdata_in = b[i];
      if (i == 7) peer_rdy_n = 1;
    end
    @(posedge sclk_out);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!summary_done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int f0, i0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 buf_full", buf_full, 0);
    chk("R1 irq", rx_irq, 0);
    chk("R1 ovr", ovr_err, 0);
    chk("R1 sclk_out", sclk_out, 1);
    chk("R1 rdy_n_out", rdy_n_out, 0);

    slave_send(8'hA5, 1, 0);
    chk("R6 full", buf_full, 1);
    chk("R8 busy", rdy_n_out, 1);
    cpu_read();
    chk("R7 cleared", buf_full, 0);
    chk("R8 ready", rdy_n_out, 0);

    slave_send(8'h01, 1, 0);
    chk("R2 lsb", rx_data, 8'h01);
    cpu_read();

    slave_send(8'h3C, 1, 0);
    i0 = irqs;
    slave_send(8'hC3, 0, 0);
    chk("R9 ovr set", ovr_err, 1);
    chk("R9 data kept", rx_data, 8'h3C);
    chk("R9 no irq", irqs, i0);
    chk("R9 still full", buf_full, 1);
    cpu_read();
    chk("R10 ovr across read", ovr_err, 1);
    @(negedge clk); ovr_clr = 1;
    @(negedge clk); ovr_clr = 0;
    chk("R10 ovr cleared", ovr_err, 0);

    slave_send(8'h5A, 1, 0);
    slave_send(8'h96, 1, 1);
    chk("R11 no overrun", ovr_err, 0);
    chk("R11 new data", rx_data, 8'h96);
    chk("R11 full", buf_full, 1);
    cpu_read();

    mode_master = 1;
    clk_div = 8'd3;
    repeat (4) @(negedge clk);
    f0 = falls;
    repeat (100) @(negedge clk);
    chk("R3 no clock while peer busy", falls - f0, 0);
    chk("R3 idle high", sclk_out, 1);
    chk("R8 master rdy_n high", rdy_n_out, 1);

    f0 = falls;
    master_recv(8'h6B);
    chk("R4 eight pulses", falls - f0, 8);
    chk("R4 half period", rise_cyc - fall_cyc, 4);
    chk("R5 master full", buf_full, 1);
    cpu_read();
    repeat (20) @(negedge clk);
    chk("R3 stops after frame", falls - f0, 8);

    clk_div = 8'd5;
    f0 = falls;
    master_recv(8'h80);
    chk("R4 eight pulses div5", falls - f0, 8);
    chk("R4 half period div5", rise_cyc - fall_cyc, 6);
    cpu_read();

    repeat (10) @(negedge clk);
    chk("R6 queue drained", expq.size(), 0);
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule